// File: doc/BRIEF.md
# Multiply-Accumulate Coprocessor with Half-Word Readout

This block is the arithmetic side of a coprocessor that hangs off a 16-bit CPU. The CPU writes a 7-bit control word. The low four bits of that word choose an operation. The upper three bits choose which 16-bit half of which 32-bit result register appears on the read port. Operations include signed and unsigned 16x16 multiplication and multiply-accumulate. Each one takes two 16-bit operands and finishes in a single cycle. Each MAC step also copies the previous accumulator into the second result register. Accumulation overflow is collected in a sticky flag.

The operand path is a single-beat strobe, `op_valid`, and the block has no `ready` signal. Every operation finishes in the cycle it is issued, so an issued operand pair is always accepted and back-pressure never arises. Division codes are left to a neighbouring divider, so this block does nothing on them. Readout is combinational from the stored control word and the result registers.

Top module: `cpmac_copro`

## Requirements
- R1: After reset, both result registers, the control word and the overflow flag are zero, so `cp_out` reads 0.
- R2: On a cycle with `mode_wr` high, `mode_din` is stored: bits [3:0] are the operation code and bits [6:4] are the readout select. An operation issued in the same cycle as a control-word write executes the previously stored code.
- R3: Readout select 0 gives register 0 bits [15:0], 1 gives register 0 bits [31:16], 2 gives register 1 bits [15:0] and 3 gives register 1 bits [31:16]. Select values 4 to 7 give 0.
- R4: Code 0 with `op_valid` clears both result registers and the overflow flag.
- R5: Code 1 loads register 0 with {`op_a`,`op_b`}, with `op_a` in bits [31:16]. Register 1 is unchanged.
- R6: Codes 2 (unsigned) and 3 (two's-complement signed) write the 32-bit product of `op_a` and `op_b` to register 0. Register 1 is unchanged.
- R7: Codes 4 (unsigned) and 5 (signed) set register 0 to its old value plus the product, modulo 2^32, and copy the old register 0 into register 1.
- R8: On codes 4 and 5 the flag is set by a carry out of bit 31 (unsigned) or by signed overflow of the addition (signed). It stays set until code 0.
- R9: Code 8 is an unsigned MAC, code 9 a signed MAC, and code 10 subtracts the signed product from register 0. Each of them copies the old register 0 into register 1, and none of them changes the flag.
- R10: Codes 6, 7 and 11 to 15 leave both result registers and the flag unchanged.
- R11: With `op_valid` low, the result registers and the flag hold, even across control-word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Store `mode_din` as the control word |
| mode_din | input | 7 | Control word: [6:4] readout select, [3:0] operation code |
| op_valid | input | 1 | Execute the stored operation on the operands this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| cp_out | output | 16 | Selected half of a result register |
| ovf_flag | output | 1 | Sticky accumulation overflow |

## Verification
A control-word write and an operation issue can land in the same cycle. The question then is which code governs the operation. The bench raises `mode_wr` with a clear code and `op_valid` together while the stored code is a no-op. It then reads both registers and the flag back and expects them untouched, since the old code must win. A separate cycle writes the clear code with `op_valid` low, and the registers must still hold.

// File: rtl/cpmac_pkg.sv
package cpmac_pkg;
  localparam int DW    = 16;
  localparam int AW    = 2 * DW;
  localparam int OPW   = 4;
  localparam int SELW  = 3;
  localparam int MODEW = OPW + SELW;
  localparam int NREG  = 2;

  typedef enum logic [2:0] {
    K_NONE,
    K_CLR,
    K_LOAD,
    K_MUL,
    K_MAC,
    K_MSUB
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     sgn;
    logic     flag_en;
  } op_ctl_t;
endpackage

// File: rtl/cpmac_decode.sv
module cpmac_decode
  import cpmac_pkg::*;
(
  input  logic [OPW-1:0] code,
  output op_ctl_t        ctl
);
  always_comb begin
    ctl = '{kind: K_NONE, sgn: 1'b0, flag_en: 1'b0};
    case (code)
      4'd0:  ctl.kind = K_CLR;
      4'd1:  ctl.kind = K_LOAD;
      4'd2:  ctl.kind = K_MUL;
      4'd3:  begin ctl.kind = K_MUL; ctl.sgn = 1'b1; end
      4'd4:  begin ctl.kind = K_MAC; ctl.flag_en = 1'b1; end
      4'd5:  begin ctl.kind = K_MAC; ctl.sgn = 1'b1; ctl.flag_en = 1'b1; end
      4'd8:  ctl.kind = K_MAC;
      4'd9:  begin ctl.kind = K_MAC; ctl.sgn = 1'b1; end
      4'd10: begin ctl.kind = K_MSUB; ctl.sgn = 1'b1; end
      default: ctl.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/cpmac_arith.sv
module cpmac_arith
  import cpmac_pkg::*;
#(
  parameter int W = DW,
  localparam int WW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [WW-1:0] acc,
  input  logic          sgn,
  output logic [WW-1:0] prod,
  output logic [WW-1:0] sum,
  output logic [WW-1:0] diff,
  output logic          ovf
);
  logic [WW-1:0] ext_a, ext_b;
  logic [WW:0]   wide_sum;
  logic          s_ovf;

  always_comb begin
    ext_a    = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    ext_b    = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    prod     = ext_a * ext_b;
    wide_sum = {1'b0, acc} + {1'b0, prod};
    sum      = wide_sum[WW-1:0];
    diff     = acc - prod;
    s_ovf    = (acc[WW-1] == prod[WW-1]) && (sum[WW-1] != acc[WW-1]);
    ovf      = sgn ? s_ovf : wide_sum[WW];
  end
endmodule

// File: rtl/cpmac_outsel.sv
module cpmac_outsel
  import cpmac_pkg::*;
#(
  parameter int W = DW,
  parameter int NR = NREG,
  localparam int NH = 2 * NR,
  localparam int IW = $clog2(NH)
) (
  input  logic [NR-1:0][2*W-1:0] regs,
  input  logic [SELW-1:0]        sel,
  output logic [W-1:0]           dout
);
  logic [NH-1:0][W-1:0] halves;

  for (genvar g = 0; g < NR; g++) begin : g_split
    assign halves[2*g]   = regs[g][W-1:0];
    assign halves[2*g+1] = regs[g][2*W-1:W];
  end

  always_comb begin
    if (32'(sel) < NH) dout = halves[sel[IW-1:0]];
    else               dout = '0;
  end
endmodule

// File: rtl/cpmac_copro.sv
module cpmac_copro
  import cpmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODEW-1:0]  mode_din,
  input  logic              op_valid,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  output logic [DW-1:0]     cp_out,
  output logic              ovf_flag
);
  logic [MODEW-1:0]          mode_q;
  logic [AW-1:0]             r0_q, r1_q;
  logic [NREG-1:0][AW-1:0]   regs;
  op_ctl_t                   ctl;
  logic [AW-1:0]             prod, sum, diff;
  logic                      ovf;

  cpmac_decode u_dec (.code(mode_q[OPW-1:0]), .ctl(ctl));

  cpmac_arith #(.W(DW)) u_alu (
    .a(op_a), .b(op_b), .acc(r0_q), .sgn(ctl.sgn),
    .prod(prod), .sum(sum), .diff(diff), .ovf(ovf)
  );

  assign regs = {r1_q, r0_q};

  cpmac_outsel #(.W(DW), .NR(NREG)) u_sel (
    .regs(regs), .sel(mode_q[MODEW-1:OPW]), .dout(cp_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q     <= '0;
      r1_q     <= '0;
      ovf_flag <= 1'b0;
    end else if (op_valid) begin
      case (ctl.kind)
        K_CLR: begin
          r0_q     <= '0;
          r1_q     <= '0;
          ovf_flag <= 1'b0;
        end
        K_LOAD: r0_q <= {op_a, op_b};
        K_MUL:  r0_q <= prod;
        K_MAC: begin
          r1_q <= r0_q;
          r0_q <= sum;
          if (ctl.flag_en && ovf) ovf_flag <= 1'b1;
        end
        K_MSUB: begin
          r1_q <= r0_q;
          r0_q <= diff;
        end
        default: ;
      endcase
    end
  end

  // R11: no operation, no state change
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(r0_q) && $stable(r1_q) && $stable(ovf_flag));

  // R4: clear empties everything
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && ctl.kind == K_CLR |=> r0_q == '0 && r1_q == '0 && !ovf_flag);

  // R8: flag is sticky until clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(op_valid && ctl.kind == K_CLR) |=> ovf_flag);

  // R9: non-flagging codes never raise the flag
  a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !ctl.flag_en && !ovf_flag |=> !ovf_flag);

  // R7: accumulate steps push old accumulator into register 1
  a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (ctl.kind == K_MAC || ctl.kind == K_MSUB) |=> r1_q == $past(r0_q));

  // R10: no-op codes hold state
  a_r10_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && ctl.kind == K_NONE |=> $stable(r0_q) && $stable(r1_q) && $stable(ovf_flag));

  // R3: out-of-range select reads zero
  a_r3_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[MODEW-1] |-> cp_out == '0);
endmodule

// File: tb/cpmac_copro_bench.sv
`timescale 1ns/1ps
module cpmac_copro_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [6:0]  mode_din = '0;
  logic        op_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [15:0] cp_out;
  logic        ovf_flag;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  cpmac_copro u_cpmac_copro (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_din(mode_din),
    .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .cp_out(cp_out), .ovf_flag(ovf_flag)
  );

  always #4 clk = ~clk;

  // {op, a, b, expected r0, expected r1, expected flag}
  localparam int NV = 19;
  localparam logic [100:0] VEC [NV] = '{
    {4'd1,  16'h1234, 16'h5678, 32'h12345678, 32'h00000000, 1'b0},
    {4'd2,  16'hFFFF, 16'hFFFF, 32'hFFFE0001, 32'h00000000, 1'b0},
    {4'd3,  16'hFFFF, 16'h0002, 32'hFFFFFFFE, 32'h00000000, 1'b0},
    {4'd4,  16'h0001, 16'h0003, 32'h00000001, 32'hFFFFFFFE, 1'b1},
    {4'd0,  16'h0000, 16'h0000, 32'h00000000, 32'h00000000, 1'b0},
    {4'd1,  16'h7FFF, 16'hFFFF, 32'h7FFFFFFF, 32'h00000000, 1'b0},
    {4'd5,  16'h0001, 16'h0001, 32'h80000000, 32'h7FFFFFFF, 1'b1},
    {4'd0,  16'h0000, 16'h0000, 32'h00000000, 32'h00000000, 1'b0},
    {4'd5,  16'hFFFF, 16'h0005, 32'hFFFFFFFB, 32'h00000000, 1'b0},
    {4'd4,  16'h0002, 16'h0002, 32'hFFFFFFFF, 32'hFFFFFFFB, 1'b0},
    {4'd8,  16'h0001, 16'h0001, 32'h00000000, 32'hFFFFFFFF, 1'b0},
    {4'd9,  16'h8000, 16'h8000, 32'h40000000, 32'h00000000, 1'b0},
    {4'd10, 16'h0002, 16'hFFFE, 32'h40000004, 32'h40000000, 1'b0},
    {4'd7,  16'h0005, 16'h0005, 32'h40000004, 32'h40000000, 1'b0},
    {4'd12, 16'h0003, 16'h0004, 32'h40000004, 32'h40000000, 1'b0},
    {4'd2,  16'h8000, 16'h0002, 32'h00010000, 32'h40000000, 1'b0},
    {4'd5,  16'h8000, 16'h7FFF, 32'hC0018000, 32'h00010000, 1'b0},
    {4'd4,  16'hFFFF, 16'hFFFF, 32'hBFFF8001, 32'hC0018000, 1'b1},
    {4'd3,  16'h0002, 16'h0003, 32'h00000006, 32'hC0018000, 1'b1}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R4";
      4'd1: return "R5";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5: return "R7/R8";
      4'd8, 4'd9, 4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic write_mode(input logic [2:0] sel, input logic [3:0] op);
    @(negedge clk);
    mode_wr  = 1'b1;
    mode_din = {sel, op};
    @(negedge clk);
    mode_wr  = 1'b0;
  endtask

  task automatic read32(input int regsel, output logic [31:0] val);
    write_mode(3'(2 * regsel), 4'hF);
    val[15:0] = cp_out;
    write_mode(3'(2 * regsel + 1), 4'hF);
    val[31:16] = cp_out;
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    write_mode(3'd0, op);
    op_valid = 1'b1;
    op_a = a;
    op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "cp_out after reset", 32'(cp_out), 32'h0);
    check("R1", "flag after reset", 32'(ovf_flag), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read32(0, v); check("R1", "r0 after reset", v, 32'h0);
    read32(1, v); check("R1", "r1 after reset", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      op = VEC[i][100:97];
      issue(op, VEC[i][96:81], VEC[i][80:65]);
      read32(0, v); check(req_of(op), $sformatf("vec %0d r0", i), v, VEC[i][64:33]);
      read32(1, v); check(req_of(op), $sformatf("vec %0d r1", i), v, VEC[i][32:1]);
      check(req_of(op), $sformatf("vec %0d flag", i), 32'(ovf_flag), 32'(VEC[i][0]));
    end

    // R3: select 4..7 read zero while both registers are nonzero
    for (int s = 4; s < 8; s++) begin
      write_mode(3'(s), 4'hF);
      check("R3", $sformatf("select %0d", s), 32'(cp_out), 32'h0);
    end

    // R2: clear code written in the same cycle as op issue; old no-op code governs
    @(negedge clk);
    mode_wr = 1'b1; mode_din = {3'd0, 4'd0};
    op_valid = 1'b1; op_a = 16'hAAAA; op_b = 16'h5555;
    @(negedge clk);
    mode_wr = 1'b0; op_valid = 1'b0;
    check("R2", "flag after same-cycle write", 32'(ovf_flag), 32'h1);
    read32(0, v); check("R2", "r0 after same-cycle write", v, 32'h6);
    read32(1, v); check("R2", "r1 after same-cycle write", v, 32'hC0018000);

    // R11: load code written with op_valid low changes nothing
    write_mode(3'd0, 4'd1);
    write_mode(3'd0, 4'd0);
    read32(0, v); check("R11", "r0 with no issue", v, 32'h6);
    read32(1, v); check("R11", "r1 with no issue", v, 32'hC0018000);
    check("R11", "flag with no issue", 32'(ovf_flag), 32'h1);

    // R8: clear drops the sticky flag
    issue(4'd0, 16'h0, 16'h0);
    check("R8", "flag after clear", 32'(ovf_flag), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule